// File: doc/BRIEF.md
# Multi-Format PCM Audio Serial Receiver

This block turns a stereo PCM serial stream into parallel samples. The stream has three wires: a bit clock, a word clock that marks the channel, and a serial data line. All three are asynchronous to the block's system clock. They are brought into the `clk` domain and the data line is sampled on each bit-clock rising edge. Each half-frame of the word clock is gathered into one word. The word is aligned according to the selected framing, and the sample is sign-extended to 32 bits.

A 3-bit format code picks one of three framings and the sample length. Left-justified framing places the MSB in the first bit slot after a word-clock edge. The I2S-style framing delays the MSB by one slot. Right-justified framing keeps only the last N bits before the next word-clock edge. Bits that the framing does not claim are ignored. When a right word completes after a complete left word, the pair is shown on the outputs with a one-cycle strobe. A half-frame with too few bit slots for the selected length raises a one-cycle frame error flag and drops the pair.

Top module: `pcm_rx_top`

## Requirements
- R1: `fmt_i` selects the framing and length: 000 right-justified 16-bit, 001 right-justified 20-bit, 010 left-justified 24-bit, 011 I2S 24-bit, 100 right-justified 24-bit, 101 right-justified 32-bit, 110 left-justified 32-bit, 111 I2S 32-bit. The code is held steady while out of reset.
- R2: In left-justified framing, the MSB is the data bit taken at the first bit-clock rise after a word-clock edge, and the following N-1 rises carry the rest of the word in descending order. Later bits in the half-frame are ignored. Word clock high marks the left channel.
- R3: In I2S framing, the bit taken at the first rise after a word-clock edge is ignored, and the MSB comes at the second rise. Word clock low marks the left channel.
- R4: In right-justified framing, the sample is the last N bits taken before the next word-clock edge, MSB first. All earlier bits in the half-frame are ignored. Word clock high marks the left channel.
- R5: `left_o` and `right_o` carry the N-bit sample sign-extended to 32 bits.
- R6: `valid_o` pulses for exactly one cycle once a right word is closed by the following word-clock edge. `left_o` and `right_o` change only in that cycle and hold their values otherwise.
- R7: A half-frame with fewer rises than the framing needs (N, or N+1 for I2S) gives a one-cycle `frame_err_o` pulse and no pair. `frame_err_o` and `valid_o` never pulse in the same cycle.
- R8: The partial half-frame seen first after reset produces nothing. A right word with no complete left word before it since the last pair is dropped with no pulse.
- R9: While `rst` is high, and in the cycle after, `valid_o` and `frame_err_o` are low and `left_o` and `right_o` are zero.
- R10: Data is sampled only at bit-clock rising edges. A change on `sdata_i` while the bit clock stays high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 3 | Format code (framing and sample length) |
| bck_i | input | 1 | Serial bit clock, asynchronous |
| lrck_i | input | 1 | Word clock marking the channel, asynchronous |
| sdata_i | input | 1 | Serial audio data, asynchronous |
| left_o | output | 32 | Sign-extended left sample |
| right_o | output | 32 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| frame_err_o | output | 1 | One-cycle strobe for a short half-frame |

## Verification
All eight format codes are driven with stereo pairs whose left and right values differ. The unused bit slots are filled with ones. A swapped channel, an off-by-one MSB slot or a wrong right-justified window would therefore show up as a wrong value. Negative samples at each length test the sign extension. The bit-slot counts are tried both at the minimum ratio and with spare slots. This shows whether alignment depends on the half-frame length. The data line toggles during every high bit-clock phase, which would expose sampling at any point other than the rising edge. One stream carries a short left half-frame between good pairs. It must produce exactly one error pulse, drop the following right word, and then recover.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    localparam int SAMPLE_W = 32;
    localparam int LEN_W    = 6;
    localparam int IDX_W    = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        FRM_MSB = 2'd0,
        FRM_LSB = 2'd1,
        FRM_I2S = 2'd2
    } framing_e;

    typedef struct packed {
        framing_e               framing;
        logic [LEN_W-1:0]       len;
    } fmt_cfg_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0]    data;
        logic                   is_left;
        logic                   ok;
    } word_t;

    function automatic fmt_cfg_t decode_fmt(input logic [2:0] sel);
        fmt_cfg_t c;
        case (sel)
            3'd0:    c = fmt_cfg_t'{FRM_LSB, 6'd16};
            3'd1:    c = fmt_cfg_t'{FRM_LSB, 6'd20};
            3'd2:    c = fmt_cfg_t'{FRM_MSB, 6'd24};
            3'd3:    c = fmt_cfg_t'{FRM_I2S, 6'd24};
            3'd4:    c = fmt_cfg_t'{FRM_LSB, 6'd24};
            3'd5:    c = fmt_cfg_t'{FRM_LSB, 6'd32};
            3'd6:    c = fmt_cfg_t'{FRM_MSB, 6'd32};
            default: c = fmt_cfg_t'{FRM_I2S, 6'd32};
        endcase
        return c;
    endfunction

    // Replicate bit len-1 into every position at or above len.
    function automatic logic [SAMPLE_W-1:0] sign_ext(input logic [SAMPLE_W-1:0] raw,
                                                     input logic [LEN_W-1:0]    len);
        logic [SAMPLE_W-1:0] res;
        logic [IDX_W-1:0]    top;
        top = IDX_W'(len - 6'd1);
        for (int i = 0; i < SAMPLE_W; i++) begin
            res[i] = (i < int'(len)) ? raw[i] : raw[top];
        end
        return res;
    endfunction

    // Channel identity from the word-clock level; I2S inverts the sense.
    function automatic logic lr_is_left(input framing_e f, input logic lr);
        return (f == FRM_I2S) ? !lr : lr;
    endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcm_rx_word.sv
module pcm_rx_word
    import pcm_rx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     lr_i,
    input  logic     din_i,
    input  fmt_cfg_t cfg_i,
    output logic     word_vld_o,
    output word_t    word_o
);
    localparam int PAD_W = CNT_W - LEN_W;

    logic [SAMPLE_W-1:0] acc_q, next_acc, base_acc;
    logic [CNT_W-1:0]    cnt_q, base_cnt, cnt_inc, off, pos, len_ext, need;
    logic [IDX_W-1:0]    slot;
    logic                cur_lr_q, started_q, primed_q, boundary;

    always_comb begin
        len_ext  = {{PAD_W{1'b0}}, cfg_i.len};
        off      = (cfg_i.framing == FRM_I2S) ? CNT_W'(1) : '0;
        need     = len_ext + off;
        boundary = started_q && (lr_i != cur_lr_q);
        base_cnt = boundary ? '0 : cnt_q;
        base_acc = boundary ? '0 : acc_q;
        cnt_inc  = (base_cnt == '1) ? base_cnt : base_cnt + CNT_W'(1);
        pos      = base_cnt - off;
        slot     = IDX_W'(len_ext - CNT_W'(1) - pos);
        next_acc = base_acc;
        if (cfg_i.framing == FRM_LSB) begin
            next_acc = {base_acc[SAMPLE_W-2:0], din_i};
        end else if ((base_cnt >= off) && (pos < len_ext)) begin
            next_acc[slot] = din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            cnt_q      <= '0;
            cur_lr_q   <= 1'b0;
            started_q  <= 1'b0;
            primed_q   <= 1'b0;
            word_vld_o <= 1'b0;
            word_o     <= '0;
        end else begin
            word_vld_o <= 1'b0;
            if (tick_i) begin
                started_q <= 1'b1;
                cur_lr_q  <= lr_i;
                acc_q     <= next_acc;
                cnt_q     <= cnt_inc;
                if (boundary) begin
                    primed_q       <= 1'b1;
                    word_vld_o     <= primed_q;
                    word_o.data    <= sign_ext(acc_q, cfg_i.len);
                    word_o.is_left <= lr_is_left(cfg_i.framing, cur_lr_q);
                    word_o.ok      <= (cnt_q >= need);
                end
            end
        end
    end
endmodule

// File: rtl/pcm_rx_pair.sv
module pcm_rx_pair
    import pcm_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                word_vld_i,
    input  word_t               word_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                frame_err_o
);
    logic [SAMPLE_W-1:0] left_hold_q;
    logic                have_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold_q <= '0;
            have_left_q <= 1'b0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
            if (word_vld_i) begin
                if (!word_i.ok) begin
                    frame_err_o <= 1'b1;
                    have_left_q <= 1'b0;
                end else if (word_i.is_left) begin
                    left_hold_q <= word_i.data;
                    have_left_q <= 1'b1;
                end else if (have_left_q) begin
                    left_o      <= left_hold_q;
                    right_o     <= word_i.data;
                    valid_o     <= 1'b1;
                    have_left_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_rx_top.sv
module pcm_rx_top
    import pcm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          fmt_i,
    input  logic                bck_i,
    input  logic                lrck_i,
    input  logic                sdata_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                frame_err_o
);
    logic [2:0] pins_s;
    logic       bck_d_q, tick;
    fmt_cfg_t   cfg;
    word_t      word;
    logic       word_vld;

    pcm_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({sdata_i, lrck_i, bck_i}),
        .q_o (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) bck_d_q <= 1'b0;
        else     bck_d_q <= pins_s[0];
    end

    assign tick = pins_s[0] && !bck_d_q;
    assign cfg  = decode_fmt(fmt_i);

    pcm_rx_word #(.CNT_W(CNT_W)) u_word (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .lr_i       (pins_s[1]),
        .din_i      (pins_s[2]),
        .cfg_i      (cfg),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    pcm_rx_pair u_pair (
        .clk         (clk),
        .rst         (rst),
        .word_vld_i  (word_vld),
        .word_i      (word),
        .left_o      (left_o),
        .right_o     (right_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o)
    );
endmodule

// File: rtl/pcm_rx_checker.sv
module pcm_rx_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  fmt_i,
    input logic [31:0] left_o,
    input logic [31:0] right_o,
    input logic        valid_o,
    input logic        frame_err_o
);
    logic [5:0] n_bits;
    always_comb begin
        case (fmt_i)
            3'd0:    n_bits = 6'd16;
            3'd1:    n_bits = 6'd20;
            3'd5,
            3'd6,
            3'd7:    n_bits = 6'd32;
            default: n_bits = 6'd24;
        endcase
    end

    function automatic logic upper_uniform(input logic [31:0] v, input logic [5:0] n);
        logic [31:0] sh;
        sh = 32'($signed(v) >>> (n - 6'd1));
        return (sh == 32'd0) || (sh == 32'hFFFF_FFFF);
    endfunction

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid_o && !frame_err_o && left_o == 32'd0 && right_o == 32'd0));

    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    a_r6_hold_left: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(left_o));

    a_r6_hold_right: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(right_o));

    a_r7_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && frame_err_o));

    a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o);

    a_r5_sign_ext: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (upper_uniform(left_o, n_bits) && upper_uniform(right_o, n_bits)));
endmodule

bind pcm_rx_top pcm_rx_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .fmt_i       (fmt_i),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o)
);

// File: tb/pcm_rx_top_bench.sv
module pcm_rx_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt = 3'd2;
    logic        bck = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic [31:0] left_o, right_o;
    logic        valid_o, frame_err_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    typedef struct {
        bit          is_err;
        logic [31:0] l;
        logic [31:0] r;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    pcm_rx_top u_pcm_rx_top (
        .clk(clk), .rst(rst), .fmt_i(fmt), .bck_i(bck), .lrck_i(lrck),
        .sdata_i(sdata), .left_o(left_o), .right_o(right_o),
        .valid_o(valid_o), .frame_err_o(frame_err_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // framing: 0 left-justified, 1 right-justified, 2 I2S
    task automatic ref_fmt(input logic [2:0] code, output int fr, output int n);
        case (code)
            3'd0: begin fr = 1; n = 16; end
            3'd1: begin fr = 1; n = 20; end
            3'd2: begin fr = 0; n = 24; end
            3'd3: begin fr = 2; n = 24; end
            3'd4: begin fr = 1; n = 24; end
            3'd5: begin fr = 1; n = 32; end
            3'd6: begin fr = 0; n = 32; end
            default: begin fr = 2; n = 32; end
        endcase
    endtask

    function automatic logic [31:0] sx(input logic [31:0] v, input int n);
        logic signed [31:0] t;
        t = $signed(v << (32 - n));
        return 32'(t >>> (32 - n));
    endfunction

    function automatic logic [31:0] next_val();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Data changes at the bit-clock fall; toggles again mid-high (R10 noise).
    task automatic send_bit(input logic lr, input logic b);
        @(negedge clk);
        bck = 1'b0; lrck = lr; sdata = b;
        repeat (3) @(negedge clk);
        bck = 1'b1;
        repeat (2) @(negedge clk);
        sdata = ~b;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_half(input logic lr, input logic [31:0] v, input int n,
                             input int slots, input int fr);
        for (int k = 0; k < slots; k++) begin
            logic b;
            b = 1'b1;
            if (fr == 0 && k < n)                 b = v[n-1-k];
            else if (fr == 2 && k >= 1 && k <= n) b = v[n-k];
            else if (fr == 1 && k >= slots - n)   b = v[slots-1-k];
            send_bit(lr, b);
        end
    endtask

    task automatic do_reset(input logic [2:0] code, input logic idle_lr);
        @(negedge clk);
        rst = 1'b1; fmt = code; bck = 1'b0; lrck = idle_lr; sdata = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!valid_o && !frame_err_o, "R9 strobes after reset", {30'd0, valid_o, frame_err_o}, 32'd0);
        chk(left_o == 32'd0, "R9 left_o after reset", left_o, 32'd0);
        chk(right_o == 32'd0, "R9 right_o after reset", right_o, 32'd0);
    endtask

    task automatic finish_stream(input logic left_lv, input string tag);
        repeat (3) send_bit(left_lv, 1'b0);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    task automatic send_pair(input logic left_lv, input int n, input int slots,
                             input int fr, input bit neg, input string tag);
        logic [31:0] l, r;
        exp_t e;
        l = next_val(); r = next_val();
        if (neg) l[n-1] = 1'b1;
        send_half(left_lv, l, n, slots, fr);
        send_half(!left_lv, r, n, slots, fr);
        e.is_err = 0; e.l = sx(l, n); e.r = sx(r, n); e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic session(input logic [2:0] code, input int slots, input int npairs, input string tag);
        int fr, n;
        logic left_lv;
        ref_fmt(code, fr, n);
        left_lv = (fr == 2) ? 1'b0 : 1'b1;
        do_reset(code, !left_lv);
        repeat (3) send_bit(!left_lv, 1'b1);   // partial half-frame, R8
        for (int p = 0; p < npairs; p++) send_pair(left_lv, n, slots, fr, p[0], tag);
        finish_stream(left_lv, {tag, " R6 pairs all delivered"});
    endtask

    always @(negedge clk) begin
        if (!rst && (valid_o || frame_err_o)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected output strobe", {30'd0, valid_o, frame_err_o}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_err) begin
                    chk(frame_err_o && !valid_o, {e.tag, " R7 error strobe"},
                        {30'd0, valid_o, frame_err_o}, 32'd1);
                end else begin
                    chk(valid_o && !frame_err_o, {e.tag, " R6 valid strobe"},
                        {30'd0, valid_o, frame_err_o}, 32'd2);
                    chk(left_o == e.l, {e.tag, " R5 left sample"}, left_o, e.l);
                    chk(right_o == e.r, {e.tag, " R5 right sample"}, right_o, e.r);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        session(3'd2, 32, 3, "R1 R2 R10 lj24/64fs");
        session(3'd2, 24, 2, "R1 R2 lj24/48fs");
        session(3'd6, 32, 2, "R1 R2 lj32");
        session(3'd3, 32, 3, "R1 R3 R10 i2s24");
        session(3'd7, 40, 2, "R1 R3 i2s32");
        session(3'd0, 16, 2, "R1 R4 rj16/32fs");
        session(3'd0, 32, 2, "R1 R4 rj16/64fs");
        session(3'd1, 32, 2, "R1 R4 rj20");
        session(3'd4, 24, 2, "R1 R4 rj24/48fs");
        session(3'd5, 32, 2, "R1 R4 rj32");

        // Short left half-frame: one error, following right word dropped (R7, R8).
        begin
            exp_t e;
            do_reset(3'd2, 1'b0);
            repeat (3) send_bit(1'b0, 1'b1);
            send_pair(1'b1, 24, 32, 0, 1, "R7 before short");
            send_half(1'b1, 32'h00AB_CDEF, 24, 20, 0);
            e.is_err = 1; e.l = 0; e.r = 0; e.tag = "R7 short left";
            exp_q.push_back(e);
            send_half(1'b0, 32'h0012_3456, 24, 32, 0);
            send_pair(1'b1, 24, 32, 0, 0, "R8 after drop");
            finish_stream(1'b1, "R7 R8 error stream drained");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule